// File: doc/BRIEF.md
# Pixel-Pair YCbCr 4:2:2 to RGB Converter

This block turns a stream of 4:2:2 luma/chroma pixel pairs into 8-bit RGB pixels for a display path. Each accepted input carries two luma samples and one blue-difference and one red-difference sample, and both pixels of the pair share that chroma. Inside the block the chroma is used for both pixels, which gives each pixel its own full set of components. Each pixel is then converted with fixed-point integer coefficients pre-scaled by 1024. The scale is removed with an arithmetic right shift of 10 bits, and the result is saturated into the 0..255 range.

The datapath is a three-stage pipeline. Its last stage loads both converted pixels into a pair of result registers. A small reader then presents them on the output one per clock: the first pixel of the pair, then the second. The producer may offer a new pair at most every second clock, so that the pair registers drain before they are reloaded.

Top module: `ycc_pair_rgb`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `out_valid` is 0.
- R2: The red output equals the luma term plus 1436·(Cr−128), shifted right arithmetically by 10 bits and then saturated.
- R3: The green output equals the luma term minus 352·(Cb−128) minus 731·(Cr−128), shifted right arithmetically by 10 bits and then saturated. The luma term is 1024·Y.
- R4: The blue output equals the luma term plus 1815·(Cb−128), shifted right arithmetically by 10 bits and then saturated.
- R5: A negative shifted result is output as 0.
- R6: A shifted result above 255 is output as 255.
- R7: Both pixels of a pair are converted with the same Cb and Cr. The first pixel uses `in_y0` and the second uses `in_y1`. When Cb = Cr = 128, R = G = B = Y.
- R8: A pair is accepted when `in_valid` is 1 at a rising edge k. Its first pixel is on the outputs with `out_valid` = 1 in the cycle after edge k+2. The second pixel follows in the next cycle. `in_valid` is never 1 on two consecutive edges.
- R9: `out_second` is 0 while the first pixel (`in_y0`) is shown and 1 while the second pixel (`in_y1`) is shown.
- R10: Input values at edges where `in_valid` is 0 are ignored. `out_valid` drops to 0 after the second pixel unless a new pair was accepted, and an idle input produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pair offered this edge |
| in_cb | input | PIX_W | Shared blue-difference sample |
| in_y0 | input | PIX_W | Luma of the first pixel |
| in_cr | input | PIX_W | Shared red-difference sample |
| in_y1 | input | PIX_W | Luma of the second pixel |
| out_valid | output | 1 | A converted pixel is on the outputs |
| out_second | output | 1 | 0: first pixel of the pair, 1: second |
| out_r | output | PIX_W | Red |
| out_g | output | PIX_W | Green |
| out_b | output | PIX_W | Blue |

## Verification
The bench builds the block with its default parameters: 8-bit samples, a 10-bit shift and the four standard-definition coefficients. The intermediate width is therefore 21 bits, and extreme chroma drives every channel past both saturation rails, so both clamps are exercised. The input ranges cover chroma offsets of −128 and +127 on full-scale luma. These offsets reach the largest positive sum (blue) and the largest negative sum (red and blue at zero luma) that the width has to hold.

// File: rtl/ycc_rgb_pkg.sv
package ycc_rgb_pkg;
  // default fixed-point conversion constants, scaled by 2**10
  localparam int DEF_PIX_W = 8;
  localparam int DEF_FRAC  = 10;
  localparam int DEF_K_RV  = 1436;
  localparam int DEF_K_GU  = 352;
  localparam int DEF_K_GV  = 731;
  localparam int DEF_K_BU  = 1815;

  localparam int PAIR_N = 2;

  typedef enum logic {
    SLOT_FIRST  = 1'b0,
    SLOT_SECOND = 1'b1
  } pair_slot_e;
endpackage

// File: rtl/ycc_chroma_stage.sv
module ycc_chroma_stage #(
  parameter int PIX_W = 8,
  parameter int FRAC  = 10,
  parameter int SUM_W = 21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PIX_W-1:0]        cb,
  input  logic [PIX_W-1:0]        cr,
  input  logic [PIX_W-1:0]        y_in  [ycc_rgb_pkg::PAIR_N],
  output logic                    s1_valid,
  output logic signed [PIX_W:0]   s1_cb_off,
  output logic signed [PIX_W:0]   s1_cr_off,
  output logic signed [SUM_W-1:0] s1_y_sc [ycc_rgb_pkg::PAIR_N]
);
  localparam logic [PIX_W:0] MID = (PIX_W+1)'(1 << (PIX_W-1));

  function automatic logic signed [PIX_W:0] centre(input logic [PIX_W-1:0] c);
    return $signed({1'b0, c}) - $signed(MID);
  endfunction

  function automatic logic signed [SUM_W-1:0] scale_luma(input logic [PIX_W-1:0] y);
    logic signed [SUM_W-1:0] t;
    t = '0;
    t[PIX_W+FRAC-1:FRAC] = y;
    return t;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_cb_off <= '0;
      s1_cr_off <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_cb_off <= centre(cb);
        s1_cr_off <= centre(cr);
      end
    end
  end

  // one luma scaler per pixel of the pair, both reuse the shared chroma
  for (genvar k = 0; k < ycc_rgb_pkg::PAIR_N; k++) begin : g_luma
    always_ff @(posedge clk) begin
      if (!rst_n)        s1_y_sc[k] <= '0;
      else if (in_valid) s1_y_sc[k] <= scale_luma(y_in[k]);
    end
  end
endmodule

// File: rtl/ycc_matrix_stage.sv
module ycc_matrix_stage #(
  parameter int PIX_W = 8,
  parameter int SUM_W = 21,
  parameter int K_RV  = 1436,
  parameter int K_GU  = 352,
  parameter int K_GV  = 731,
  parameter int K_BU  = 1815
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s1_valid,
  input  logic signed [PIX_W:0]   s1_cb_off,
  input  logic signed [PIX_W:0]   s1_cr_off,
  input  logic signed [SUM_W-1:0] s1_y_sc [ycc_rgb_pkg::PAIR_N],
  output logic                    s2_valid,
  output logic signed [SUM_W-1:0] s2_r [ycc_rgb_pkg::PAIR_N],
  output logic signed [SUM_W-1:0] s2_g [ycc_rgb_pkg::PAIR_N],
  output logic signed [SUM_W-1:0] s2_b [ycc_rgb_pkg::PAIR_N]
);
  localparam logic signed [SUM_W-1:0] C_RV = SUM_W'(K_RV);
  localparam logic signed [SUM_W-1:0] C_GU = SUM_W'(K_GU);
  localparam logic signed [SUM_W-1:0] C_GV = SUM_W'(K_GV);
  localparam logic signed [SUM_W-1:0] C_BU = SUM_W'(K_BU);

  function automatic logic signed [SUM_W-1:0] chroma_term(
    input logic signed [PIX_W:0]   off,
    input logic signed [SUM_W-1:0] coef
  );
    logic signed [SUM_W-1:0] wide;
    wide = SUM_W'(off);
    return wide * coef;
  endfunction

  // chroma products are common to both pixels of the pair
  logic signed [SUM_W-1:0] t_rv, t_gu, t_gv, t_bu;
  always_comb begin
    t_rv = chroma_term(s1_cr_off, C_RV);
    t_gu = chroma_term(s1_cb_off, C_GU);
    t_gv = chroma_term(s1_cr_off, C_GV);
    t_bu = chroma_term(s1_cb_off, C_BU);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  for (genvar k = 0; k < ycc_rgb_pkg::PAIR_N; k++) begin : g_mat
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s2_r[k] <= '0;
        s2_g[k] <= '0;
        s2_b[k] <= '0;
      end else if (s1_valid) begin
        s2_r[k] <= s1_y_sc[k] + t_rv;
        s2_g[k] <= s1_y_sc[k] - t_gu - t_gv;
        s2_b[k] <= s1_y_sc[k] + t_bu;
      end
    end
  end
endmodule

// File: rtl/ycc_clamp_stage.sv
module ycc_clamp_stage #(
  parameter int PIX_W = 8,
  parameter int FRAC  = 10,
  parameter int SUM_W = 21
) (
  input  logic signed [SUM_W-1:0] sum_r [ycc_rgb_pkg::PAIR_N],
  input  logic signed [SUM_W-1:0] sum_g [ycc_rgb_pkg::PAIR_N],
  input  logic signed [SUM_W-1:0] sum_b [ycc_rgb_pkg::PAIR_N],
  output logic [PIX_W-1:0]        pix_r [ycc_rgb_pkg::PAIR_N],
  output logic [PIX_W-1:0]        pix_g [ycc_rgb_pkg::PAIR_N],
  output logic [PIX_W-1:0]        pix_b [ycc_rgb_pkg::PAIR_N]
);
  localparam logic signed [SUM_W-1:0] TOP_V = SUM_W'((1 << PIX_W) - 1);

  // divide by the coefficient scale, then pin to the output range
  function automatic logic [PIX_W-1:0] shift_sat(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] q;
    q = s >>> FRAC;
    if (q[SUM_W-1])   return '0;
    else if (q > TOP_V) return '1;
    else              return q[PIX_W-1:0];
  endfunction

  for (genvar k = 0; k < ycc_rgb_pkg::PAIR_N; k++) begin : g_sat
    always_comb begin
      pix_r[k] = shift_sat(sum_r[k]);
      pix_g[k] = shift_sat(sum_g[k]);
      pix_b[k] = shift_sat(sum_b[k]);
    end
  end
endmodule

// File: rtl/ycc_pair_reader.sv
module ycc_pair_reader #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pair_load,
  input  logic [PIX_W-1:0] new_r [ycc_rgb_pkg::PAIR_N],
  input  logic [PIX_W-1:0] new_g [ycc_rgb_pkg::PAIR_N],
  input  logic [PIX_W-1:0] new_b [ycc_rgb_pkg::PAIR_N],
  output logic             out_valid,
  output logic             out_second,
  output logic [PIX_W-1:0] out_r,
  output logic [PIX_W-1:0] out_g,
  output logic [PIX_W-1:0] out_b
);
  import ycc_rgb_pkg::*;

  logic [PIX_W-1:0] hold_r [PAIR_N];
  logic [PIX_W-1:0] hold_g [PAIR_N];
  logic [PIX_W-1:0] hold_b [PAIR_N];
  pair_slot_e       slot;
  logic             shown;

  for (genvar k = 0; k < PAIR_N; k++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_r[k] <= '0;
        hold_g[k] <= '0;
        hold_b[k] <= '0;
      end else if (pair_load) begin
        hold_r[k] <= new_r[k];
        hold_g[k] <= new_g[k];
        hold_b[k] <= new_b[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shown <= 1'b0;
      slot  <= SLOT_FIRST;
    end else if (pair_load) begin
      shown <= 1'b1;
      slot  <= SLOT_FIRST;
    end else if (shown && slot == SLOT_FIRST) begin
      slot  <= SLOT_SECOND;
    end else begin
      shown <= 1'b0;
      slot  <= SLOT_FIRST;
    end
  end

  always_comb begin
    out_valid  = shown;
    out_second = (slot == SLOT_SECOND);
    out_r      = out_second ? hold_r[1] : hold_r[0];
    out_g      = out_second ? hold_g[1] : hold_g[0];
    out_b      = out_second ? hold_b[1] : hold_b[0];
  end
endmodule

// File: rtl/ycc_pair_rgb.sv
module ycc_pair_rgb #(
  parameter int PIX_W = ycc_rgb_pkg::DEF_PIX_W,
  parameter int FRAC  = ycc_rgb_pkg::DEF_FRAC,
  parameter int K_RV  = ycc_rgb_pkg::DEF_K_RV,
  parameter int K_GU  = ycc_rgb_pkg::DEF_K_GU,
  parameter int K_GV  = ycc_rgb_pkg::DEF_K_GV,
  parameter int K_BU  = ycc_rgb_pkg::DEF_K_BU
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_cb,
  input  logic [PIX_W-1:0] in_y0,
  input  logic [PIX_W-1:0] in_cr,
  input  logic [PIX_W-1:0] in_y1,
  output logic             out_valid,
  output logic             out_second,
  output logic [PIX_W-1:0] out_r,
  output logic [PIX_W-1:0] out_g,
  output logic [PIX_W-1:0] out_b
);
  import ycc_rgb_pkg::*;

  // sign, luma scale, and headroom for two chroma terms
  localparam int SUM_W = PIX_W + FRAC + 3;

  logic [PIX_W-1:0]        y_pair [PAIR_N];
  logic                    s1_valid;
  logic signed [PIX_W:0]   s1_cb_off, s1_cr_off;
  logic signed [SUM_W-1:0] s1_y_sc [PAIR_N];
  logic                    s2_valid;
  logic signed [SUM_W-1:0] s2_r [PAIR_N];
  logic signed [SUM_W-1:0] s2_g [PAIR_N];
  logic signed [SUM_W-1:0] s2_b [PAIR_N];
  logic [PIX_W-1:0]        sat_r [PAIR_N];
  logic [PIX_W-1:0]        sat_g [PAIR_N];
  logic [PIX_W-1:0]        sat_b [PAIR_N];
  logic                    pair_load;

  assign y_pair[0] = in_y0;
  assign y_pair[1] = in_y1;
  assign pair_load = s2_valid;

  ycc_chroma_stage #(.PIX_W(PIX_W), .FRAC(FRAC), .SUM_W(SUM_W)) u_chroma (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .cb(in_cb), .cr(in_cr), .y_in(y_pair),
    .s1_valid(s1_valid), .s1_cb_off(s1_cb_off), .s1_cr_off(s1_cr_off),
    .s1_y_sc(s1_y_sc)
  );

  ycc_matrix_stage #(
    .PIX_W(PIX_W), .SUM_W(SUM_W),
    .K_RV(K_RV), .K_GU(K_GU), .K_GV(K_GV), .K_BU(K_BU)
  ) u_matrix (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid),
    .s1_cb_off(s1_cb_off), .s1_cr_off(s1_cr_off), .s1_y_sc(s1_y_sc),
    .s2_valid(s2_valid), .s2_r(s2_r), .s2_g(s2_g), .s2_b(s2_b)
  );

  ycc_clamp_stage #(.PIX_W(PIX_W), .FRAC(FRAC), .SUM_W(SUM_W)) u_clamp (
    .sum_r(s2_r), .sum_g(s2_g), .sum_b(s2_b),
    .pix_r(sat_r), .pix_g(sat_g), .pix_b(sat_b)
  );

  ycc_pair_reader #(.PIX_W(PIX_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .pair_load(pair_load),
    .new_r(sat_r), .new_g(sat_g), .new_b(sat_b),
    .out_valid(out_valid), .out_second(out_second),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );
endmodule

// File: rtl/ycc_pair_rgb_chk.sv
module ycc_pair_rgb_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_cb,
  input logic [PIX_W-1:0] in_y0,
  input logic [PIX_W-1:0] in_cr,
  input logic [PIX_W-1:0] in_y1,
  input logic             out_valid,
  input logic             out_second,
  input logic [PIX_W-1:0] out_r,
  input logic [PIX_W-1:0] out_g,
  input logic [PIX_W-1:0] out_b,
  input logic             pair_load
);
  localparam logic [PIX_W-1:0] MID = PIX_W'(1 << (PIX_W-1));

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R1

  AST_GREY_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid, 3) && $past(in_cb, 3) == MID && $past(in_cr, 3) == MID
    |-> out_r == $past(in_y0, 3) && out_g == $past(in_y0, 3) && out_b == $past(in_y0, 3)); // R7

  AST_FIRST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid, 3) |-> out_valid && !out_second); // R8

  AST_IN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !in_valid); // R8

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    pair_load |=> out_valid && !out_second); // R9

  AST_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_second |=> out_valid && out_second); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid, 3) && !$past(in_valid, 4) |-> !out_valid); // R10
endmodule

bind ycc_pair_rgb ycc_pair_rgb_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_cb(in_cb), .in_y0(in_y0), .in_cr(in_cr), .in_y1(in_y1),
  .out_valid(out_valid), .out_second(out_second),
  .out_r(out_r), .out_g(out_g), .out_b(out_b),
  .pair_load(pair_load)
);

// File: tb/ycc_pair_rgb_bench.sv
module ycc_pair_rgb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int N_RANDOM   = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_cb = '0, in_y0 = '0, in_cr = '0, in_y1 = '0;
  logic       out_valid, out_second;
  logic [7:0] out_r, out_g, out_b;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ycc_pair_rgb u_ycc_pair_rgb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_cb(in_cb), .in_y0(in_y0), .in_cr(in_cr), .in_y1(in_y1),
    .out_valid(out_valid), .out_second(out_second),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  // one channel: a*(ca-128) + b*(cb-128) on top of 1024*y, floor-divided and pinned
  function automatic int expect_chan(int y, int ka, int ca, int kb, int cb);
    int s, q;
    s = y * 1024 + ka * (ca - 128) + kb * (cb - 128);
    if (s >= 0) q = s / 1024;
    else        q = -((-s + 1023) / 1024);
    if (q < 0)   q = 0;
    if (q > 255) q = 255;
    return q;
  endfunction

  function automatic int exp_red(int y, int cb, int cr);
    return expect_chan(y, 1436, cr, 0, cb);
  endfunction
  function automatic int exp_green(int y, int cb, int cr);
    return expect_chan(y, -352, cb, -731, cr);
  endfunction
  function automatic int exp_blue(int y, int cb, int cr);
    return expect_chan(y, 1815, cb, 0, cr);
  endfunction

  task automatic check_idle(string tag);
    n_vec++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: out_valid=%b expected 0", tag, out_valid);
    end
  endtask

  task automatic check_pix(string tag, logic sec, int er, int eg, int eb);
    n_vec++;
    if (out_valid !== 1'b1 || out_second !== sec ||
        out_r != er || out_g != eg || out_b != eb) begin
      n_bad++;
      $display("FAIL %s: got v=%b s=%b rgb=%0d,%0d,%0d expected v=1 s=%b rgb=%0d,%0d,%0d",
               tag, out_valid, out_second, out_r, out_g, out_b, sec, er, eg, eb);
    end
  endtask

  // accept at edge k, first pixel after edge k+2, second after edge k+3
  task automatic run_pair(string tag, int cb, int y0, int cr, int y1);
    @(negedge clk);
    in_valid = 1'b1;
    in_cb = 8'(cb); in_y0 = 8'(y0); in_cr = 8'(cr); in_y1 = 8'(y1);
    @(negedge clk);
    in_valid = 1'b0;
    in_cb = 8'($urandom); in_y0 = 8'($urandom);
    in_cr = 8'($urandom); in_y1 = 8'($urandom);
    @(negedge clk);
    check_idle({tag, " R8 not early"});
    @(negedge clk);
    check_pix({tag, " R2 R3 R4 R7 R9 first"}, 1'b0,
              exp_red(y0, cb, cr), exp_green(y0, cb, cr), exp_blue(y0, cb, cr));
    @(negedge clk);
    check_pix({tag, " R2 R3 R4 R7 R9 second"}, 1'b1,
              exp_red(y1, cb, cr), exp_green(y1, cb, cr), exp_blue(y1, cb, cr));
    @(negedge clk);
    check_idle({tag, " R10 drop after pair"});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: quiet during and just after reset
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after release");

    // directed corners
    run_pair("black R7",          128,  16, 128,  16);
    run_pair("white R7",          128, 235, 128, 235);
    run_pair("shared chroma R7",   90,  16, 200, 235);
    run_pair("all high R6",       255, 255, 255, 255);
    run_pair("all low R5",          0,   0,   0,   0);
    run_pair("green low R5",      255,   0, 255,  10);
    run_pair("green high R6",       0, 255,   0, 240);
    run_pair("red only R2 R6",    128, 200, 255,  60);
    run_pair("blue only R4 R5",     0,  30, 128, 250);

    // R10: idle input with changing data must stay silent
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_cb = 8'($urandom); in_y0 = 8'($urandom);
      in_cr = 8'($urandom); in_y1 = 8'($urandom);
      check_idle("R10 idle input");
    end

    // constrained random pairs, chroma biased toward the rails on some
    for (int i = 0; i < N_RANDOM; i++) begin
      int cb, cr;
      if (($urandom % 4) == 0) begin
        cb = (($urandom % 2) != 0) ? 255 - int'($urandom % 8) : int'($urandom % 8);
        cr = (($urandom % 2) != 0) ? 255 - int'($urandom % 8) : int'($urandom % 8);
      end else begin
        cb = int'($urandom % 256);
        cr = int'($urandom % 256);
      end
      run_pair("random", cb, int'($urandom % 256), cr, int'($urandom % 256));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule